// File: doc/BRIEF.md
# Shift-Subtract Restoring Divider

This block divides an 8-bit unsigned dividend by a 4-bit unsigned divisor over several clock cycles. It returns a 4-bit quotient, a 4-bit remainder and an overflow flag. A caller raises `start_i` for one cycle while the block is idle and presents the operands on that cycle. `busy_o` stays high while the block works. `done_o` pulses for one cycle when a result or an overflow verdict is ready.

The datapath is a single working register one bit wider than the dividend. Each cycle shifts it left, and the quotient bit that the cycle produces fills the low position the shift freed. The block checks for overflow once, straight after loading, and does no dividing when the quotient cannot fit. After that check, each step compares the upper five register bits with the divisor. When those bits are not smaller, the step subtracts the divisor and records a 1 as the quotient bit. A small controller sequences the steps with one flip-flop per state.

Top module: `shsub_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `ovf_o` are all low.
- R2: When `start_i` is high while `busy_o` is low, the block captures both operands and `busy_o` is high in the next cycle.
- R3: If the upper four dividend bits, as an unsigned number, are greater than or equal to the divisor, `ovf_o` and `done_o` go high one cycle after the accepting edge, `busy_o` drops in that same cycle, and no division takes place.
- R4: A divisor of zero is always reported through R3's overflow path.
- R5: Without overflow, `done_o` goes high five cycles after the accepting edge (one check cycle and four step cycles). In that cycle, `quo_o` equals dividend / divisor.
- R6: In that same `done_o` cycle, `rem_o` equals dividend mod divisor.
- R7: `done_o` is high for exactly one cycle per operation, and `busy_o` is low whenever `done_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored: the running operation's timing and its results are those of the operands captured first.
- R9: A `start_i` pulse in the same cycle that `done_o` is high is accepted as a new operation.
- R10: Accepting a new operation clears `ovf_o` in the next cycle. Otherwise `ovf_o` holds its value until the next accepted start.
- R11: The control state is held one-hot: exactly one state flip-flop is set in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a division; only acted on while idle |
| dividend_i | input | 8 | Unsigned dividend, sampled when a start is accepted |
| divisor_i | input | 4 | Unsigned divisor, sampled when a start is accepted |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result or overflow verdict is ready |
| ovf_o | output | 1 | Quotient does not fit in 4 bits, or the divisor is zero |
| quo_o | output | 4 | Quotient, valid while `done_o` is high and `ovf_o` is low |
| rem_o | output | 4 | Remainder, valid while `done_o` is high and `ovf_o` is low |

## Verification
Two events can share a cycle: the completion of one operation (`done_o`) and the acceptance of the next (`start_i` while idle). The bench issues each new operation on the very cycle `done_o` appears, so these back-to-back starts occur hundreds of times, for both overflow and normal results. In each case the reference model expects the old result to appear intact that cycle and the new operation to begin on the following edge. Starts injected one cycle into an operation, while `busy_o` is high, are judged the same way: the model expects them to leave both the timing and the result untouched.

// File: rtl/shsub_pkg.sv
package shsub_pkg;
    // Position of each state flip-flop in the one-hot control vector
    localparam int ST_IDLE  = 0;
    localparam int ST_CHECK = 1;
    localparam int ST_STEP  = 2;
    localparam int NUM_ST   = 3;
endpackage

// File: rtl/shsub_cmpsub.sv
module shsub_cmpsub #(
    parameter int DVS_W = 4
) (
    input  logic [DVS_W:0]   upper_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             ge_o,
    output logic [DVS_W:0]   diff_o
);
    logic [DVS_W:0] dvs_ext;

    always_comb begin
        dvs_ext = {1'b0, divisor_i};
        ge_o    = (upper_i >= dvs_ext);
        diff_o  = upper_i - dvs_ext;
    end
endmodule

// File: rtl/shsub_ctrl.sv
module shsub_ctrl
    import shsub_pkg::*;
#(
    parameter int STEPS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              ge_i,
    output logic              load_o,
    output logic              ovf_set_o,
    output logic              shift0_o,
    output logic              step_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [NUM_ST-1:0] state_o
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

    typedef struct packed {
        logic [NUM_ST-1:0] st;
        logic [CW-1:0]     cnt;
        logic              done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load_o     = 1'b0;
        ovf_set_o  = 1'b0;
        shift0_o   = 1'b0;
        step_o     = 1'b0;
        last_o     = 1'b0;
        if (ctl_q.st[ST_IDLE]) begin
            if (start_i) begin
                load_o   = 1'b1;
                ctl_d.st = NUM_ST'(1) << ST_CHECK;
            end
        end else if (ctl_q.st[ST_CHECK]) begin
            if (ge_i) begin
                ovf_set_o  = 1'b1;
                ctl_d.done = 1'b1;
                ctl_d.st   = NUM_ST'(1) << ST_IDLE;
            end else begin
                shift0_o  = 1'b1;
                ctl_d.cnt = '0;
                ctl_d.st  = NUM_ST'(1) << ST_STEP;
            end
        end else if (ctl_q.st[ST_STEP]) begin
            step_o = 1'b1;
            last_o = (ctl_q.cnt == LAST_CNT);
            if (last_o) begin
                ctl_d.done = 1'b1;
                ctl_d.st   = NUM_ST'(1) << ST_IDLE;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end else begin
            ctl_d.st = NUM_ST'(1) << ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.st   <= NUM_ST'(1) << ST_IDLE;
            ctl_q.cnt  <= '0;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o  = ~ctl_q.st[ST_IDLE];
    assign done_o  = ctl_q.done;
    assign state_o = ctl_q.st;
endmodule

// File: rtl/shsub_divider.sv
module shsub_divider
    import shsub_pkg::*;
#(
    parameter int DVD_W = 8,
    parameter int DVS_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic [DVD_W-DVS_W-1:0] quo_o,
    output logic [DVS_W-1:0] rem_o
);
    localparam int QW = DVD_W - DVS_W;  // quotient width, also step count
    localparam int RW = DVD_W + 1;      // working register width
    localparam int UW = DVS_W + 1;      // compared upper slice width

    typedef struct packed {
        logic [RW-1:0]    x;
        logic [DVS_W-1:0] y;
        logic             ovf;
    } dp_t;

    dp_t dp_d, dp_q;

    logic              load, ovf_set, shift0, step, last, ge;
    logic [UW-1:0]     upper, diff;
    logic [NUM_ST-1:0] st;
    logic [RW-1:0]     step_val;

    assign upper = dp_q.x[RW-1 -: UW];

    shsub_cmpsub #(.DVS_W(DVS_W)) u_cmpsub (
        .upper_i   (upper),
        .divisor_i (dp_q.y),
        .ge_o      (ge),
        .diff_o    (diff)
    );

    shsub_ctrl #(.STEPS(QW)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .ge_i      (ge),
        .load_o    (load),
        .ovf_set_o (ovf_set),
        .shift0_o  (shift0),
        .step_o    (step),
        .last_o    (last),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .state_o   (st)
    );

    always_comb begin
        dp_d     = dp_q;
        step_val = {(ge ? diff : upper), dp_q.x[QW-1:1], ge};
        if (load) begin
            dp_d.x   = {1'b0, dividend_i};
            dp_d.y   = divisor_i;
            dp_d.ovf = 1'b0;
        end
        if (ovf_set) begin
            dp_d.ovf = 1'b1;
        end
        if (shift0) begin
            dp_d.x = dp_q.x << 1;
        end
        if (step) begin
            dp_d.x = last ? step_val : (step_val << 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign ovf_o = dp_q.ovf;
    assign quo_o = dp_q.x[QW-1:0];
    assign rem_o = dp_q.x[DVD_W-1 -: DVS_W];
endmodule

// File: rtl/shsub_divider_chk.sv
module shsub_divider_chk
    import shsub_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              ovf_o,
    input logic [NUM_ST-1:0] state_oh
);
    assert_onehot_state_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(state_oh) == 1);

    assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    assert_ovf_with_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> done_o);

    assert_ovf_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> !ovf_o);

    assert_ovf_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(start_i && !busy_o) && !busy_o) |=> $stable(ovf_o));
endmodule

bind shsub_divider shsub_divider_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ovf_o    (ovf_o),
    .state_oh (st)
);

// File: tb/tb_shsub_divider.sv
module tb_shsub_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] dvd = '0;
    logic [3:0] dvs = '0;
    logic       busy, done, ovf;
    logic [3:0] quo, rem;

    always #10 clk = ~clk;  // 50 MHz

    shsub_divider dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .dividend_i(dvd), .divisor_i(dvs),
        .busy_o(busy), .done_o(done), .ovf_o(ovf),
        .quo_o(quo), .rem_o(rem)
    );

    int checks = 0;
    int fails  = 0;
    bit run_on = 0;

    // behavioural reference model, advanced once per rising edge
    bit m_busy = 0, m_done = 0, m_ovf = 0;
    int m_ph = 0, m_a = 0, m_b = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ovf = 0; m_ph = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_ph = 0; m_a = int'(dvd); m_b = int'(dvs); m_ovf = 0;
                end
            end else begin
                m_ph++;
                if (m_ph == 1 && (m_a / 16) >= m_b) begin
                    m_ovf = 1; m_done = 1; m_busy = 0;
                end else if (m_ph == 5) begin
                    m_done = 1; m_busy = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_on) begin
            chk(busy == m_busy, "R2/R8 busy", int'(busy), int'(m_busy));
            chk(done == m_done, "R5/R7 done", int'(done), int'(m_done));
            chk(ovf == m_ovf, (m_b == 0) ? "R4 ovf" : "R3/R10 ovf", int'(ovf), int'(m_ovf));
            if (m_done && !m_ovf) begin
                chk(int'(quo) == m_a / m_b, "R5 quotient", int'(quo), m_a / m_b);
                chk(int'(rem) == m_a % m_b, "R6 remainder", int'(rem), m_a % m_b);
            end
        end
    end

    // issue one operation at a negedge; optionally poke start while busy (R8)
    task automatic op(input logic [7:0] a, input logic [3:0] b, input bit poke);
        while (busy) @(negedge clk);
        start = 1'b1; dvd = a; dvs = b;
        @(negedge clk);
        if (poke) begin
            start = 1'b1; dvd = ~a; dvs = b + 4'd1;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        // returns at the done cycle: the next op starts here (R9)
    endtask

    task automatic body();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_on = 1;
        op(8'd135, 4'd13, 0);   // R5 R6: 10 r 5
        op(8'hFF, 4'hF, 0);     // R3 overflow
        op(8'hEF, 4'hF, 0);     // largest fit: 15 r 14
        op(8'd10, 4'd0, 0);     // R4 divide by zero
        op(8'd0, 4'd1, 0);      // R10 ovf cleared
        op(8'd100, 4'd7, 1);    // R8 start while busy
        op(8'hF0, 4'd3, 1);     // R8 poke during overflow check
        repeat (3) @(negedge clk);
        for (int i = 0; i < 400; i++) begin
            op(8'($urandom), 4'($urandom), ($urandom % 4) == 0);
            if (($urandom % 3) == 0) begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        fork
            body();
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule